// File: doc/BRIEF.md
# Serial Game-Pad Poller and Parallelizer

This block reads a latch-and-clock serial game pad and presents its buttons as twelve parallel, active-low lines to a host board. It repeats a fixed sequence without pause. The sequence is one positive latch pulse with the pad clock held high, then sixteen pad-clock cycles. The block samples the pad's serial line on each falling clock edge. Twelve bits carry buttons. The last four are clocked out and thrown away.

Every output is written in the same system-clock edge that samples its bit, so a change of a button reaches the host within one poll. A poll takes a few hundred microseconds, far shorter than a video frame. Between updates each output holds its last value.

The four face buttons are remapped to the host layout: pad Y gives host A, pad B gives host B, pad X gives host C and pad A gives host D. The directions, Select, Start, L and R pass straight through.

All timing is counted in system-clock ticks derived from a clock-frequency parameter. An optional idle gap between polls is set in microseconds and defaults to zero. The serial input passes through a two-flop synchronizer, so the half period must be at least three ticks.

Top module: `pad_poller`

## Requirements
- R1: While reset is asserted, all twelve button outputs are 1 (released), pad_latch is 0, pad_clk is 1 and poll_done is 0.
- R2: Each poll begins with pad_latch high for exactly LATCH_US x (CLK_FREQ_HZ/1e6) cycles, and pad_clk stays high for the whole latch.
- R3: After the latch falls, pad_clk stays high for one half period of HALF_US x (CLK_FREQ_HZ/1e6) cycles. It then makes 16 cycles, each low for one half period and high for one half period, and it idles high.
- R4: The pad's serial level is sampled when pad_clk falls. The output for that bit takes the sampled level unchanged, so 0 means pressed.
- R5: Pad bit 0 (B) drives btn_b_n, bit 1 (Y) drives btn_a_n, bit 8 (A) drives btn_d_n and bit 9 (X) drives btn_c_n.
- R6: The other eight bits pass straight through: bit 2 to Select, bit 3 to Start, bits 4 to 7 to Up, Down, Left and Right, bit 10 to L and bit 11 to R.
- R7: The output of pad bit k changes in the cycle of the k-th pad_clk fall. The output of bit k+1 still shows the previous poll's value at that moment.
- R8: Bits 12 to 15 of the stream have no effect on any output, whatever their level.
- R9: Button outputs change only in a cycle in which pad_clk falls. At all other times they hold.
- R10: With IDLE_US = 0, the next latch rises in the first cycle after the 16th low phase ends, so the distance between latch rises is (LATCH_US + 32 x HALF_US) x (CLK_FREQ_HZ/1e6) cycles.
- R11: poll_done is high for exactly one cycle per poll. That cycle is the first one after the 16th low phase, and with IDLE_US = 0 it coincides with the first cycle of the next latch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pad_data | input | 1 | Serial data from the pad |
| pad_latch | output | 1 | Latch pulse to the pad, active high |
| pad_clk | output | 1 | Shift clock to the pad, idles high |
| btn_a_n | output | 1 | Host button A (pad Y), active low |
| btn_b_n | output | 1 | Host button B (pad B), active low |
| btn_c_n | output | 1 | Host button C (pad X), active low |
| btn_d_n | output | 1 | Host button D (pad A), active low |
| btn_up_n | output | 1 | Up, active low |
| btn_down_n | output | 1 | Down, active low |
| btn_left_n | output | 1 | Left, active low |
| btn_right_n | output | 1 | Right, active low |
| btn_select_n | output | 1 | Select, active low |
| btn_start_n | output | 1 | Start, active low |
| btn_l_n | output | 1 | Left shoulder, active low |
| btn_r_n | output | 1 | Right shoulder, active low |
| poll_done | output | 1 | One-cycle strobe after the 16th sample |

## Verification
Two events fall in the same cycle here. The end-of-poll strobe lands on the very edge that raises the next latch. The bench changes the modelled pad's buttons in that same cycle. It then judges three things: the next poll must carry the new pattern, the latch-to-latch distance must stay exact, and the strobe must be seen together with the latch. Each button write also shares its edge with the pad-clock fall. This is provoked by sending each pattern followed by its complement. It is judged by checking, at every fall, that the bit just sampled is new and the next bit is still the old one.

// File: rtl/pad_pkg.sv
package pad_pkg;

  localparam int PAD_BITS = 16;
  localparam int BTN_COUNT = 12;
  localparam int BIT_IDX_W = $clog2(PAD_BITS);

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_LATCH = 2'd1,
    ST_HIGH  = 2'd2,
    ST_LOW   = 2'd3
  } poll_state_e;

  // Host output slot order:
  // 0 A, 1 B, 2 C, 3 D, 4 up, 5 down, 6 left, 7 right,
  // 8 select, 9 start, 10 L, 11 R.
  // Maps a pad stream position to its host slot.
  function automatic int host_slot(input int pad_bit);
    case (pad_bit)
      0:       return 1;   // pad B -> host B
      1:       return 0;   // pad Y -> host A
      2:       return 8;   // select
      3:       return 9;   // start
      8:       return 3;   // pad A -> host D
      9:       return 2;   // pad X -> host C
      default: return pad_bit;
    endcase
  endfunction

endpackage

// File: rtl/pad_rst_sync.sv
module pad_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= 2'b00;
    else        stage_q <= {stage_q[0], 1'b1};
  end

  assign rst_sync_n = stage_q[1];

endmodule

// File: rtl/pad_sync.sv
module pad_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic dout
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb chain_d = {chain_q[STAGES-2:0], din};

  // Resets to 1 so an idle line reads as released.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '1;
    else        chain_q <= chain_d;
  end

  assign dout = chain_q[STAGES-1];

endmodule

// File: rtl/pad_timer.sv
module pad_timer #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  output logic          zero
);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_d;
  logic          cnt_en;

  assign zero = (cnt_q == '0);

  always_comb begin
    cnt_en = load || !zero;
    cnt_d  = load ? load_val : cnt_q - CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

endmodule

// File: rtl/pad_sequencer.sv
module pad_sequencer
  import pad_pkg::*;
#(
  parameter int LATCH_TICKS = 12,
  parameter int HIGH_TICKS  = 6,
  parameter int LOW_TICKS   = 6,
  parameter int IDLE_TICKS  = 0
) (
  input  logic                 clk,
  input  logic                 rst_n,
  output logic                 latch_o,
  output logic                 pclk_o,
  output logic                 sample_en,
  output logic [BIT_IDX_W-1:0] bit_idx,
  output logic                 done_o
);

  localparam int MAX_A = (LATCH_TICKS > HIGH_TICKS) ? LATCH_TICKS : HIGH_TICKS;
  localparam int MAX_B = (LOW_TICKS > IDLE_TICKS) ? LOW_TICKS : IDLE_TICKS;
  localparam int MAX_T = (MAX_A > MAX_B) ? MAX_A : MAX_B;
  localparam int CW    = (MAX_T < 2) ? 1 : $clog2(MAX_T);
  localparam logic [CW-1:0] LATCH_LD = CW'(LATCH_TICKS - 1);
  localparam logic [CW-1:0] HIGH_LD  = CW'(HIGH_TICKS - 1);
  localparam logic [CW-1:0] LOW_LD   = CW'(LOW_TICKS - 1);
  localparam logic [CW-1:0] IDLE_LD  = CW'((IDLE_TICKS > 0) ? IDLE_TICKS - 1 : 0);
  localparam logic [BIT_IDX_W-1:0] LAST_BIT = BIT_IDX_W'(PAD_BITS - 1);

  poll_state_e          state_q, state_d;
  logic [BIT_IDX_W-1:0] bit_q, bit_d;
  logic                 done_q, done_d;
  logic                 tmr_load;
  logic [CW-1:0]        tmr_val;
  logic                 tmr_zero;

  pad_timer #(.CW(CW)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (tmr_load),
    .load_val (tmr_val),
    .zero     (tmr_zero)
  );

  always_comb begin
    state_d  = state_q;
    bit_d    = bit_q;
    done_d   = 1'b0;
    tmr_load = 1'b0;
    tmr_val  = LATCH_LD;
    case (state_q)
      ST_IDLE: begin
        if (tmr_zero) begin
          state_d  = ST_LATCH;
          tmr_load = 1'b1;
          tmr_val  = LATCH_LD;
        end
      end
      ST_LATCH: begin
        if (tmr_zero) begin
          state_d  = ST_HIGH;
          tmr_load = 1'b1;
          tmr_val  = HIGH_LD;
        end
      end
      ST_HIGH: begin
        if (tmr_zero) begin
          state_d  = ST_LOW;
          tmr_load = 1'b1;
          tmr_val  = LOW_LD;
        end
      end
      default: begin
        if (tmr_zero) begin
          tmr_load = 1'b1;
          if (bit_q == LAST_BIT) begin
            bit_d  = '0;
            done_d = 1'b1;
            if (IDLE_TICKS == 0) begin
              state_d = ST_LATCH;
              tmr_val = LATCH_LD;
            end else begin
              state_d = ST_IDLE;
              tmr_val = IDLE_LD;
            end
          end else begin
            bit_d   = bit_q + BIT_IDX_W'(1);
            state_d = ST_HIGH;
            tmr_val = HIGH_LD;
          end
        end
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      bit_q   <= '0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      bit_q   <= bit_d;
      done_q  <= done_d;
    end
  end

  assign latch_o   = (state_q == ST_LATCH);
  assign pclk_o    = (state_q != ST_LOW);
  assign sample_en = (state_q == ST_HIGH) && tmr_zero;
  assign bit_idx   = bit_q;
  assign done_o    = done_q;

endmodule

// File: rtl/pad_capture.sv
module pad_capture
  import pad_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 sample_en,
  input  logic [BIT_IDX_W-1:0] bit_idx,
  input  logic                 sample_bit,
  output logic [BTN_COUNT-1:0] host_n
);

  for (genvar k = 0; k < BTN_COUNT; k++) begin : g_slot
    localparam int SLOT = host_slot(k);
    logic hit;
    logic lvl_q;

    assign hit = sample_en && (bit_idx == BIT_IDX_W'(k));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   lvl_q <= 1'b1;
      else if (hit) lvl_q <= sample_bit;
    end

    assign host_n[SLOT] = lvl_q;
  end

endmodule

// File: rtl/pad_poller.sv
module pad_poller
  import pad_pkg::*;
#(
  parameter int CLK_FREQ_HZ = 8_000_000,
  parameter int LATCH_US    = 12,
  parameter int HALF_US     = 6,
  parameter int IDLE_US     = 0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pad_data,
  output logic pad_latch,
  output logic pad_clk,
  output logic btn_a_n,
  output logic btn_b_n,
  output logic btn_c_n,
  output logic btn_d_n,
  output logic btn_up_n,
  output logic btn_down_n,
  output logic btn_left_n,
  output logic btn_right_n,
  output logic btn_select_n,
  output logic btn_start_n,
  output logic btn_l_n,
  output logic btn_r_n,
  output logic poll_done
);

  localparam int TICKS_PER_US = CLK_FREQ_HZ / 1_000_000;
  localparam int LATCH_TICKS  = TICKS_PER_US * LATCH_US;
  localparam int HALF_TICKS   = TICKS_PER_US * HALF_US;
  localparam int IDLE_TICKS   = TICKS_PER_US * IDLE_US;

  logic                 rst_core_n;
  logic                 data_s;
  logic                 sample_en;
  logic [BIT_IDX_W-1:0] bit_idx;
  logic [BTN_COUNT-1:0] host_n;

  pad_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_core_n)
  );

  pad_sync #(.STAGES(2)) u_sync (
    .clk   (clk),
    .rst_n (rst_core_n),
    .din   (pad_data),
    .dout  (data_s)
  );

  pad_sequencer #(
    .LATCH_TICKS (LATCH_TICKS),
    .HIGH_TICKS  (HALF_TICKS),
    .LOW_TICKS   (HALF_TICKS),
    .IDLE_TICKS  (IDLE_TICKS)
  ) u_seq (
    .clk       (clk),
    .rst_n     (rst_core_n),
    .latch_o   (pad_latch),
    .pclk_o    (pad_clk),
    .sample_en (sample_en),
    .bit_idx   (bit_idx),
    .done_o    (poll_done)
  );

  pad_capture u_cap (
    .clk        (clk),
    .rst_n      (rst_core_n),
    .sample_en  (sample_en),
    .bit_idx    (bit_idx),
    .sample_bit (data_s),
    .host_n     (host_n)
  );

  assign btn_a_n      = host_n[0];
  assign btn_b_n      = host_n[1];
  assign btn_c_n      = host_n[2];
  assign btn_d_n      = host_n[3];
  assign btn_up_n     = host_n[4];
  assign btn_down_n   = host_n[5];
  assign btn_left_n   = host_n[6];
  assign btn_right_n  = host_n[7];
  assign btn_select_n = host_n[8];
  assign btn_start_n  = host_n[9];
  assign btn_l_n      = host_n[10];
  assign btn_r_n      = host_n[11];

endmodule

// File: rtl/pad_poller_chk.sv
module pad_poller_chk #(
  parameter int LATCH_TICKS = 12,
  parameter int HALF_TICKS  = 6,
  parameter int IDLE_TICKS  = 0
) (
  input logic        clk,
  input logic        rst_n,
  input logic        pad_latch,
  input logic        pad_clk,
  input logic        poll_done,
  input logic [11:0] btn_n
);

  logic [15:0] latch_run_q;
  logic [15:0] low_run_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      latch_run_q <= '0;
      low_run_q   <= '0;
    end else begin
      latch_run_q <= pad_latch ? latch_run_q + 16'd1 : 16'd0;
      low_run_q   <= !pad_clk  ? low_run_q + 16'd1   : 16'd0;
    end
  end

  // R2: clock stays high while the latch is high
  a_r2_clk_high_in_latch: assert property (@(posedge clk) disable iff (!rst_n)
    pad_latch |-> pad_clk);

  // R2: latch width in ticks
  a_r2_latch_width: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pad_latch) |-> (latch_run_q == 16'(LATCH_TICKS)));

  // R3: low phase width in ticks
  a_r3_low_width: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pad_clk) |-> (low_run_q == 16'(HALF_TICKS)));

  // R9: outputs move only with a falling pad clock
  a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(btn_n) |-> $fell(pad_clk));

  // R11: strobe lasts one cycle
  a_r11_single_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    poll_done |=> !poll_done);

  if (IDLE_TICKS == 0) begin : g_no_gap
    // R10: next latch starts with the strobe
    a_r10_restart: assert property (@(posedge clk) disable iff (!rst_n)
      poll_done |-> pad_latch);
  end

endmodule

bind pad_poller pad_poller_chk #(
  .LATCH_TICKS (LATCH_TICKS),
  .HALF_TICKS  (HALF_TICKS),
  .IDLE_TICKS  (IDLE_TICKS)
) i_pad_poller_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .pad_latch (pad_latch),
  .pad_clk   (pad_clk),
  .poll_done (poll_done),
  .btn_n     ({btn_r_n, btn_l_n, btn_start_n, btn_select_n,
                btn_right_n, btn_left_n, btn_down_n, btn_up_n,
                btn_d_n, btn_c_n, btn_b_n, btn_a_n})
);

// File: tb/test_pad_poller.sv
`timescale 1ns/1ps
module test_pad_poller;

  localparam int LAT = 12;
  localparam int HALF = 6;
  localparam int PERIOD = LAT + 32 * HALF;
  localparam int NPOLL = 116;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pad_data;
  logic pad_latch, pad_clk, poll_done;
  logic btn_a_n, btn_b_n, btn_c_n, btn_d_n;
  logic btn_up_n, btn_down_n, btn_left_n, btn_right_n;
  logic btn_select_n, btn_start_n, btn_l_n, btn_r_n;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  pad_poller #(
    .CLK_FREQ_HZ (1_000_000),
    .LATCH_US    (12),
    .HALF_US     (6),
    .IDLE_US     (0)
  ) i_pad_poller (
    .clk(clk), .rst_n(rst_n), .pad_data(pad_data),
    .pad_latch(pad_latch), .pad_clk(pad_clk),
    .btn_a_n(btn_a_n), .btn_b_n(btn_b_n), .btn_c_n(btn_c_n), .btn_d_n(btn_d_n),
    .btn_up_n(btn_up_n), .btn_down_n(btn_down_n),
    .btn_left_n(btn_left_n), .btn_right_n(btn_right_n),
    .btn_select_n(btn_select_n), .btn_start_n(btn_start_n),
    .btn_l_n(btn_l_n), .btn_r_n(btn_r_n), .poll_done(poll_done)
  );

  // Pad model: press bit 1 = pressed; stream bit order B,Y,Sel,Start,U,D,L,R,A,X,L,R
  logic [11:0] press = 12'hFFF;
  logic [3:0]  tail = 4'h0;
  logic [11:0] cap = 12'h000;
  logic [11:0] cap_prev = 12'h000;
  logic [15:0] pad_sr = 16'hFFFF;
  logic lat_p = 1'b0, clk_p = 1'b1;

  assign pad_data = pad_sr[0];

  always @(negedge clk) begin
    lat_p <= pad_latch;
    clk_p <= pad_clk;
    if (lat_p && !pad_latch) begin
      pad_sr   <= {tail, ~press};
      cap_prev <= cap;
      cap      <= press;
    end else if (!clk_p && pad_clk && !pad_latch) begin
      pad_sr <= {1'b1, pad_sr[15:1]};
    end
  end

  function automatic logic out_of(input int k);
    case (k)
      0: return btn_b_n;
      1: return btn_a_n;
      2: return btn_select_n;
      3: return btn_start_n;
      4: return btn_up_n;
      5: return btn_down_n;
      6: return btn_left_n;
      7: return btn_right_n;
      8: return btn_d_n;
      9: return btn_c_n;
      10: return btn_l_n;
      default: return btn_r_n;
    endcase
  endfunction

  function automatic logic [11:0] all_out();
    logic [11:0] v;
    for (int k = 0; k < 12; k++) v[k] = out_of(k);
    return v;
  endfunction

  function automatic logic [11:0] pattern(input int i);
    int b = i / 2;
    logic [11:0] p;
    if (b < 12)       p = 12'(1 << b);
    else if (b < 24)  p = ~12'(1 << (b - 12));
    else if (b == 24) p = 12'h000;
    else if (b == 25) p = 12'hFFF;
    else              p = 12'((b * 2517 + 929) % 4096);
    return (i % 2 == 1) ? ~p : p;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  // Timing and per-bit monitor, sampled mid-cycle
  bit started = 0;
  logic lat_d = 1'b0, pclk_d = 1'b1;
  logic [11:0] out_d = 12'hFFF;
  int lat_run = 0, hi_run = 0, lo_run = 0, falls = 0, since_rise = 0, rises = 0;

  always @(negedge clk) begin
    if (rst_n) begin
      if (pad_latch && !lat_d) begin
        if (rises > 0) begin
          check(since_rise == PERIOD, "R10 latch period", since_rise, PERIOD);
          check(falls == 16, "R3 falls per poll", falls, 16);
          check(poll_done == 1'b1, "R11 strobe with latch rise", poll_done, 1);
        end
        rises++;
        since_rise = 0;
        started = 1;
      end
      since_rise++;
      if (pad_latch) begin
        lat_run++;
        if (!pad_clk) check(1'b0, "R2 clock low in latch", 0, 1);
      end
      if (lat_d && !pad_latch) begin
        check(lat_run == LAT, "R2 latch width", lat_run, LAT);
        lat_run = 0;
        falls = 0;
        hi_run = 0;
      end
      if (started && !pad_latch && pad_clk) hi_run++;
      if (!pad_clk) lo_run++;
      if (pclk_d && !pad_clk) begin
        check(hi_run == HALF, "R3 high phase", hi_run, HALF);
        hi_run = 0;
        if (falls < 12) begin
          check(out_of(falls) == ~cap[falls], "R4 sampled bit", out_of(falls), ~cap[falls]);
          if (falls < 11)
            check(out_of(falls + 1) == ~cap_prev[falls + 1], "R7 later bit still old",
                  out_of(falls + 1), ~cap_prev[falls + 1]);
        end
        falls++;
      end
      if (!pclk_d && pad_clk) begin
        check(lo_run == HALF, "R3 low phase", lo_run, HALF);
        lo_run = 0;
      end
      if (all_out() != out_d)
        check(pclk_d && !pad_clk, "R9 change off clock fall", all_out(), out_d);
      if (poll_done && !pad_latch) check(1'b0, "R10 strobe without latch", 0, 1);
      out_d = all_out();
      lat_d = pad_latch;
      pclk_d = pad_clk;
    end
  end

  // Watchdog
  initial begin
    repeat (150000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog expired actual=running expected=finished");
    finish_run();
  end

  initial begin
    repeat (4) @(negedge clk);
    // R1: reset state
    check(all_out() == 12'hFFF, "R1 outputs released", all_out(), 12'hFFF);
    check(pad_latch == 1'b0, "R1 latch low", pad_latch, 0);
    check(pad_clk == 1'b1, "R1 clock high", pad_clk, 1);
    check(poll_done == 1'b0, "R1 no strobe", poll_done, 0);
    rst_n = 1'b1;
    for (int i = 0; i < NPOLL; i++) begin
      int width;
      do @(negedge clk); while (!poll_done);
      // R8: trailing bits (driven to tail levels) leave all outputs alone
      check(all_out() == ~cap, "R8 whole word after poll", all_out(), ~cap);
      // R5: face button remap
      check(btn_a_n == ~cap[1], "R5 pad Y to host A", btn_a_n, ~cap[1]);
      check(btn_b_n == ~cap[0], "R5 pad B to host B", btn_b_n, ~cap[0]);
      check(btn_c_n == ~cap[9], "R5 pad X to host C", btn_c_n, ~cap[9]);
      check(btn_d_n == ~cap[8], "R5 pad A to host D", btn_d_n, ~cap[8]);
      // R6: pass-through group
      check({btn_r_n, btn_l_n, btn_start_n, btn_select_n} ==
            ~{cap[11], cap[10], cap[3], cap[2]}, "R6 shoulders and menu",
            {btn_r_n, btn_l_n, btn_start_n, btn_select_n},
            ~{cap[11], cap[10], cap[3], cap[2]});
      check({btn_right_n, btn_left_n, btn_down_n, btn_up_n} == ~cap[7:4],
            "R6 directions", {btn_right_n, btn_left_n, btn_down_n, btn_up_n}, ~cap[7:4]);
      // R10: latch already high in the strobe cycle
      check(pad_latch == 1'b1, "R10 immediate restart", pad_latch, 1);
      press = pattern(i);
      tail = tail + 4'd5;
      // R11: strobe is one cycle wide
      width = 1;
      @(negedge clk);
      if (poll_done) width++;
      check(width == 1, "R11 strobe width", width, 1);
    end
    finish_run();
  end

endmodule